// File: doc/BRIEF.md
# Clock Ratio Detector and Sync Monitor

This block runs on the system clock of a slave-mode audio converter. It receives the frame (left/right) clock, already sampled into the system-clock domain, and counts the system-clock cycles between rising frame edges. Each measured count is sorted into one of four ratios: 256, 384, 512 or 768 system clocks per sample. Two matching measurements in a row make the block lock to that ratio. Once locked, it produces two single-cycle enables, one at 128 times and one at 64 times the sample rate, for the decimation and modulator stages downstream.

While locked, the block checks each frame edge against the expected position. The allowed drift is measured in bit clocks, and a bit clock is one sixty-fourth or one forty-eighth of the frame, set by a mode input. If an edge comes too early, or too much time passes without one, the block drops lock and forces the converter output to zero at once. It then hunts for the ratio again. After it relocks, the output stays at zero for a fixed number of frames so that the filters can settle, and only then is it released.

Top module: `ckratio_sync_mon`

## Requirements
- R1: After reset, `locked` is 0, `zero_force` is 1, and both enables are 0.
- R2: A period within ±2 cycles of 256, 384, 512 or 768 is classified as ratio code 0, 1, 2 or 3. The code appears on `ratio` from the moment of lock and does not change while locked.
- R3: Lock needs two consecutive measured periods of the same class. The first frame edge after reset only starts a measurement. Lock is taken at the edge that ends the second matching period. Alternating classes never lock.
- R4: A period outside every window is unrecognized and resets the match history. With `bck48`=1, the 256 and 512 windows also count as unrecognized.
- R5: While locked, `en_128fs` pulses exactly 128 times and `en_64fs` exactly 64 times per steady frame. `en_64fs` only pulses together with `en_128fs`. Both stay at 0 while unlocked.
- R6: With `bck48`=0, one bit clock is ratio/64 system clocks. A locked period within ±6 bit clocks of nominal keeps lock, and this includes any drift below 5 bit clocks. A larger deviation drops lock.
- R7: With `bck48`=1, one bit clock is ratio/48 system clocks. Lock holds within ±5 bit clocks and is lost beyond that, so a drift below 4 bit clocks is always kept.
- R8: On loss, `locked` falls and `zero_force` rises in the same cycle. An early edge is detected at that edge. A late edge is detected as soon as the running count passes the limit, before the next edge arrives.
- R9: After each lock, `zero_force` stays 1 through the following 31 frame edges and falls at the 32nd. It is 1 whenever the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame clock sampled in the `clk` domain |
| bck48 | input | 1 | 1: 48 bit clocks per frame, 0: 64 |
| ratio | output | 2 | Locked ratio code: 0=256, 1=384, 2=512, 3=768 |
| locked | output | 1 | Frame clock locked to the system clock |
| zero_force | output | 1 | Converter output must be zero |
| en_128fs | output | 1 | Single-cycle enable at 128 times the sample rate |
| en_64fs | output | 1 | Single-cycle enable at 64 times the sample rate |

## Verification
The bench drives steady frames at 256, 384 and 768 cycles to show that classification, the lock instant and the 32-frame release work at more than one ratio. Periods at ±2 and ±3 cycles from nominal separate the acquisition windows from their neighbours. The bench also tests unrecognized counts and alternating classes, which must never lock. Drift frames in the 64- and 48-bit-clock modes straddle the two limits from the early side and the late side. A mid-frame probe shows that a late edge is flagged before it arrives.

// File: rtl/ckrs_pkg.sv
package ckrs_pkg;

   localparam int NUM_RATES = 4;
   localparam int FAST_DIV  = 128;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_RUN    = 2'd2
   } sync_st_e;

   // system clocks per sample for each ratio code
   function automatic int rate_nominal(input logic [1:0] code);
      case (code)
         2'd0:    return 256;
         2'd1:    return 384;
         2'd2:    return 512;
         default: return 768;
      endcase
   endfunction

   // codes legal when a frame carries 48 bit clocks
   function automatic logic rate_ok48(input logic [1:0] code);
      return (code == 2'd1) || (code == 2'd3);
   endfunction

   // allowed drift in system clocks: bit-clock limit times clocks per bit clock
   function automatic int drift_limit(input logic [1:0] code, input logic bck48,
                                      input int l64, input int l48);
      case (code)
         2'd0:    return bck48 ? (l48 * 256) / 48 : (l64 * 256) / 64;
         2'd1:    return bck48 ? (l48 * 384) / 48 : (l64 * 384) / 64;
         2'd2:    return bck48 ? (l48 * 512) / 48 : (l64 * 512) / 64;
         default: return bck48 ? (l48 * 768) / 48 : (l64 * 768) / 64;
      endcase
   endfunction

endpackage

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   output logic             edge_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             fr_q;
   logic [CNT_W-1:0] cnt_q;

   assign edge_o = frame_i & ~fr_q;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fr_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         fr_q <= frame_i;
         if (edge_o)
            cnt_q <= CNT_W'(1);
         else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
   import ckrs_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int TOL   = 2
) (
   input  logic [CNT_W-1:0] period_i,
   input  logic             bck48_i,
   output logic             valid_o,
   output logic [1:0]       code_o
);
   logic [NUM_RATES-1:0] hit;

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
      localparam int NOM = rate_nominal(2'(g));
      localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
      assign hit[g] = (period_i >= LO) && (period_i <= HI) &&
                      (!bck48_i || rate_ok48(2'(g)));
   end

   always_comb begin
      code_o = 2'd0;
      for (int i = 0; i < NUM_RATES; i++)
         if (hit[i]) code_o = 2'(i);
   end

   assign valid_o = |hit;
endmodule

// File: rtl/sync_lock_fsm.sv
module sync_lock_fsm
   import ckrs_pkg::*;
#(
   parameter int CNT_W         = 11,
   parameter int SETTLE_FRAMES = 32,
   parameter int LOSS64        = 6,
   parameter int LOSS48        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cls_valid_i,
   input  logic [1:0]       cls_code_i,
   input  logic             bck48_i,
   output logic             locked_o,
   output logic             zero_o,
   output logic [1:0]       ratio_o
);
   localparam int SW = $clog2(SETTLE_FRAMES + 1);
   localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_FRAMES - 1);

   sync_st_e         st_q;
   logic             have_edge_q, match_q;
   logic [1:0]       cand_q, ratio_q;
   logic [SW-1:0]    settle_q;
   logic [CNT_W-1:0] nom, lim, hi, lo;
   logic             drift_bad;

   always_comb begin
      nom = CNT_W'(rate_nominal(ratio_q));
      lim = CNT_W'(drift_limit(ratio_q, bck48_i, LOSS64, LOSS48));
      hi  = nom + lim;
      lo  = nom - lim;
      drift_bad = (cnt_i > hi) || (edge_i && (cnt_i < lo));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_HUNT;
         have_edge_q <= 1'b0;
         match_q     <= 1'b0;
         cand_q      <= 2'd0;
         ratio_q     <= 2'd0;
         settle_q    <= '0;
      end else begin
         unique case (st_q)
            ST_HUNT: if (edge_i) begin
               if (!have_edge_q) begin
                  have_edge_q <= 1'b1;
                  match_q     <= 1'b0;
               end else if (cls_valid_i) begin
                  if (match_q && (cand_q == cls_code_i)) begin
                     st_q     <= ST_SETTLE;
                     ratio_q  <= cls_code_i;
                     settle_q <= '0;
                     match_q  <= 1'b0;
                  end else begin
                     cand_q  <= cls_code_i;
                     match_q <= 1'b1;
                  end
               end else begin
                  match_q <= 1'b0;
               end
            end
            ST_SETTLE, ST_RUN: begin
               if (drift_bad) begin
                  st_q    <= ST_HUNT;
                  match_q <= 1'b0;
               end else if (edge_i && (st_q == ST_SETTLE)) begin
                  if (settle_q == SETTLE_LAST) st_q <= ST_RUN;
                  else                         settle_q <= settle_q + SW'(1);
               end
            end
            default: st_q <= ST_HUNT;
         endcase
      end
   end

   assign locked_o = (st_q != ST_HUNT);
   assign zero_o   = (st_q != ST_RUN);
   assign ratio_o  = ratio_q;

   // R3
   lock_needs_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> ($past(edge_i) && $past(cls_valid_i)));
   // R2
   ratio_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && $past(locked_o)) |-> $stable(ratio_o));
   // R9
   release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(zero_o) |-> $past(edge_i));
endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen
   import ckrs_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       locked_i,
   input  logic [1:0] ratio_i,
   input  logic       edge_i,
   output logic       en_fast_o,
   output logic       en_slow_o
);
   logic [DIV_W-1:0] div_q, div_last;
   logic             ph_q;

   assign div_last  = DIV_W'(rate_nominal(ratio_i) / FAST_DIV - 1);
   assign en_fast_o = locked_i && (div_q == div_last);
   assign en_slow_o = en_fast_o && ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         ph_q  <= 1'b0;
      end else if (!locked_i || edge_i) begin
         div_q <= '0;
         ph_q  <= 1'b0;
      end else if (div_q == div_last) begin
         div_q <= '0;
         ph_q  <= ~ph_q;
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/ckratio_sync_mon.sv
module ckratio_sync_mon #(
   parameter int CNT_W         = 11,
   parameter int TOL           = 2,
   parameter int SETTLE_FRAMES = 32,
   parameter int LOSS64        = 6,
   parameter int LOSS48        = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_i,
   input  logic       bck48,
   output logic [1:0] ratio,
   output logic       locked,
   output logic       zero_force,
   output logic       en_128fs,
   output logic       en_64fs
);
   localparam int DIV_W = 3;

   if ((1 << CNT_W) <= 2 * 768) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the largest ratio plus drift");
   end
   if (SETTLE_FRAMES < 1) begin : g_bad_settle
      $error("SETTLE_FRAMES must be at least 1");
   end
   if ((TOL < 0) || (TOL >= 64)) begin : g_bad_tol
      $error("TOL must keep ratio windows disjoint");
   end

   logic             fr_edge;
   logic [CNT_W-1:0] cnt;
   logic             cls_valid;
   logic [1:0]       cls_code;

   frame_period_meter #(.CNT_W(CNT_W)) meter_i (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
      .edge_o(fr_edge), .cnt_o(cnt));

   ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) class_i (
      .period_i(cnt), .bck48_i(bck48),
      .valid_o(cls_valid), .code_o(cls_code));

   sync_lock_fsm #(.CNT_W(CNT_W), .SETTLE_FRAMES(SETTLE_FRAMES),
                   .LOSS64(LOSS64), .LOSS48(LOSS48)) fsm_i (
      .clk(clk), .rst_n(rst_n), .edge_i(fr_edge), .cnt_i(cnt),
      .cls_valid_i(cls_valid), .cls_code_i(cls_code), .bck48_i(bck48),
      .locked_o(locked), .zero_o(zero_force), .ratio_o(ratio));

   rate_enable_gen #(.DIV_W(DIV_W)) enab_i (
      .clk(clk), .rst_n(rst_n), .locked_i(locked), .ratio_i(ratio),
      .edge_i(fr_edge), .en_fast_o(en_128fs), .en_slow_o(en_64fs));

   // R5
   slow_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_64fs |-> en_128fs);
   // R5
   enable_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_128fs |-> locked);
endmodule

// File: tb/ckratio_sync_mon_tb_top.sv
`timescale 1ns/1ps
module ckratio_sync_mon_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_i = 1'b0;
   logic       bck48 = 1'b0;
   logic [1:0] ratio;
   logic       locked, zero_force, en_128fs, en_64fs;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit         el;
      bit         ez;
      logic [1:0] er;
      bit         ce;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   ckratio_sync_mon dut_i (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bck48(bck48),
      .ratio(ratio), .locked(locked), .zero_force(zero_force),
      .en_128fs(en_128fs), .en_64fs(en_64fs));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      frame_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // one frame of p cycles; the expectation is for the edge that opens it
   task automatic frame(input int p, input bit el, input bit ez,
                        input logic [1:0] er, input bit ce, input int mid);
      exp_t e;
      e.el = el; e.ez = ez; e.er = er; e.ce = ce;
      q.push_back(e);
      frame_i = 1'b1;
      for (int i = 1; i < p; i++) begin
         @(negedge clk);
         if (i == p / 2) frame_i = 1'b0;
         if (mid != 0 && i == mid) begin
            // R8 late edge flagged before it arrives
            check(locked == 1'b0, "R8 late loss locked", int'(locked), 0);
            check(zero_force == 1'b1, "R8 late loss zero_force", int'(zero_force), 1);
         end
      end
      @(negedge clk);
   endtask

   task automatic frames(input int n, input int p, input bit el, input bit ez,
                         input logic [1:0] er, input bit ce);
      for (int k = 0; k < n; k++) frame(p, el, ez, er, ce, 0);
   endtask

   // monitor: pops one expectation per frame edge
   initial begin
      bit   fr_last = 1'b0;
      bit   ed;
      int   c128 = 0;
      int   c64 = 0;
      exp_t e;
      forever begin
         @(posedge clk);
         ed = frame_i && !fr_last;
         fr_last = frame_i;
         #5;
         if (ed) begin
            if (q.size() == 0) begin
               check(1'b0, "R3 unexpected frame edge", 1, 0);
            end else begin
               e = q.pop_front();
               check(locked == e.el, "R3/R6/R7 locked", int'(locked), int'(e.el));
               check(zero_force == e.ez, "R9 zero_force", int'(zero_force), int'(e.ez));
               if (e.el)
                  check(ratio == e.er, "R2 ratio", int'(ratio), int'(e.er));
               if (e.ce) begin
                  check(c128 == 128, "R5 en_128fs count", c128, 128);
                  check(c64 == 64, "R5 en_64fs count", c64, 64);
               end
            end
            c128 = 0;
            c64 = 0;
         end
         c128 += int'(en_128fs);
         c64  += int'(en_64fs);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(locked == 1'b0, "R1 locked", int'(locked), 0);
      check(zero_force == 1'b1, "R1 zero_force", int'(zero_force), 1);
      check(en_128fs == 1'b0 && en_64fs == 1'b0, "R1 enables", int'({en_128fs, en_64fs}), 0);
      do_reset();

      // R3 lock at 384 on the third edge, R9 release on the 32nd edge after it
      frames(2, 384, 0, 1, 2'd0, 0);
      frame(384, 1, 1, 2'd1, 0, 0);
      frames(31, 384, 1, 1, 2'd1, 0);
      frame(384, 1, 0, 2'd1, 0, 0);
      frames(3, 384, 1, 0, 2'd1, 1);              // R5
      // R6 drift of 5 bit clocks (30 cycles) either way keeps lock
      frame(414, 1, 0, 2'd1, 0, 0);
      frame(354, 1, 0, 2'd1, 0, 0);
      // R6/R8 late by 7 bit clocks: loss before the edge
      frame(384, 1, 0, 2'd1, 0, 0);
      frame(426, 1, 0, 2'd1, 0, 424);
      frame(384, 0, 1, 2'd0, 0, 0);
      frame(384, 0, 1, 2'd0, 0, 0);
      frame(384, 1, 1, 2'd1, 0, 0);               // R3 relock
      frames(31, 384, 1, 1, 2'd1, 0);
      frame(384, 1, 0, 2'd1, 0, 0);               // R9 after resync
      // R8 early edge by 7 bit clocks: loss at that edge
      frame(342, 1, 0, 2'd1, 0, 0);
      frame(384, 0, 1, 2'd0, 0, 0);
      frame(384, 0, 1, 2'd0, 0, 0);

      // R2/R5 at 256
      do_reset();
      frames(2, 256, 0, 1, 2'd0, 0);
      frame(256, 1, 1, 2'd0, 0, 0);
      frames(31, 256, 1, 1, 2'd0, 0);
      frame(256, 1, 0, 2'd0, 0, 0);
      frames(2, 256, 1, 0, 2'd0, 1);

      // R2 tolerance edges at 512
      do_reset();
      frame(514, 0, 1, 2'd0, 0, 0);
      frame(510, 0, 1, 2'd0, 0, 0);
      frame(512, 1, 1, 2'd2, 0, 0);
      do_reset();
      frames(4, 515, 0, 1, 2'd0, 0);              // R4 just outside window

      // R4 unrecognized count
      do_reset();
      frames(4, 300, 0, 1, 2'd0, 0);
      // R3 alternating classes never lock
      do_reset();
      for (int k = 0; k < 3; k++) begin
         frame(256, 0, 1, 2'd0, 0, 0);
         frame(384, 0, 1, 2'd0, 0, 0);
      end

      // R7 48 bit clocks per frame at 768: limit 80 cycles
      do_reset();
      bck48 = 1'b1;
      frames(2, 768, 0, 1, 2'd0, 0);
      frame(768, 1, 1, 2'd3, 0, 0);
      frame(832, 1, 1, 2'd3, 0, 0);
      frame(678, 1, 1, 2'd3, 0, 0);
      frame(768, 0, 1, 2'd0, 0, 0);
      // R4 256 not legal with 48 bit clocks
      do_reset();
      frames(4, 256, 0, 1, 2'd0, 0);
      bck48 = 1'b0;

      repeat (4) @(negedge clk);
      check(q.size() == 0, "R3 pending expectations", q.size(), 0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule